// File: doc/BRIEF.md
# Masked RAM Entry Transfer Unit

This block lets a 16-bit host bus update and inspect one wide RAM entry at a time. An entry is fourteen 32-bit words. The host stages new data in write transfer registers and chooses which bits may change in mask registers. It then pulses a commit strobe, which merges the staged data into the entry selected by the entry address.

Words 0 to 6 are masked bit by bit. Words 7 to 13 each have one enable bit in a global mask register. Bit 31 of every stored word is a check bit that holds the word's even parity. A fetch strobe copies the selected entry into the read transfer registers in a single clock. In those registers bit 31 does not hold data: it reports whether the stored check bit was wrong. The RAM is a small internal array with one row per entry.

Top module: `masked_entry_gateway`

## Requirements
- R1: After reset, every host-visible register and every stored RAM word reads as zero.
- R2: Write transfer words are read/write. The low half of word n is at address 2n and the high half at 2n+1, for addresses 0x00 to 0x1B.
- R3: Read transfer words are read-only. The low half of word n is at 0x1C+2n and the high half at 0x1D+2n. A host write to 0x1C..0x37 changes nothing.
- R4: Mask words for words 0 to 6 are read/write. The low half of mask n is at 0x38+2n and the high half at 0x39+2n. The global mask is at 0x46: bit k enables word 7+k, and bits 15..7 read as zero.
- R5: On commit, for words 0 to 6, each bit 30..0 takes the staged bit when its mask bit is 1 and keeps the stored value when its mask bit is 0. A word whose 32 mask bits are all zero stays unchanged, check bit included.
- R6: On commit, a word 7 to 13 is replaced whole when its global mask bit is 1 and is left untouched when that bit is 0.
- R7: When a word is written by a commit, its stored check bit becomes the even parity of the new bits 30..0, inverted when staged bit 31 is 1 and enabled. Bit 31 is enabled by mask bit 31 for words 0 to 6 and by the global bit for words 7 to 13. This inversion is how a parity error is injected.
- R8: On fetch, all 14 read words load in one clock. Bits 30..0 carry the stored data. Bit 31 is 1 exactly when the stored check bit disagrees with the even parity of bits 30..0.
- R9: When commit and fetch fall in the same cycle, the fetch returns the contents from before the commit. A commit or fetch uses the register values from before a host write in the same cycle.
- R10: Commit and fetch act only on the entry selected by the entry address. All other entries are unaffected.
- R11: Addresses 0x47 to 0x7F read as zero, and host writes to them change nothing.
- R12: Host read data is combinational. It reflects the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 7 | Host register address |
| hostWrEn | input | 1 | Host write enable for the addressed half |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data (combinational) |
| entryAddr | input | $clog2(ENTRIES) | Entry selected for commit and fetch |
| commitStb | input | 1 | One-cycle masked write of the staged words into the entry |
| fetchStb | input | 1 | One-cycle load of the entry into the read words |

## Verification
The merge is tried with several mask patterns:
- All-ones masks with all global bits set show that the staged data reaches every word.
- Alternating nibble and byte masks on top of an existing entry separate merged bits from kept bits.
- An all-zero bit mask and a sparse global mask confirm that the affected words stay untouched.

Staged bit 31 is set with and without its enable, so that an injected parity error can be told apart from a clean write. A later clean commit then shows the error being repaired. Fetching untouched entries tells selecting an entry apart from broadcasting to all of them. Commit, fetch and host writes issued in the same cycle expose which values each operation sees.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;
  localparam int DWORDS    = 14;
  localparam int BITMASKED = 7;
  localparam int GLOB_W    = DWORDS - BITMASKED;
  localparam int DW_W      = 32;
  localparam int HALF_W    = 16;
  localparam int ADDR_W    = 7;
  localparam int IDX_W     = $clog2(DWORDS);
  localparam int MIDX_W    = $clog2(BITMASKED);

  localparam logic [ADDR_W-1:0] RD_BASE    = 7'h1C;
  localparam logic [ADDR_W-1:0] MASK_BASE  = 7'h38;
  localparam logic [ADDR_W-1:0] GMASK_ADDR = 7'h46;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_WR,
    SEL_RD,
    SEL_MASK,
    SEL_GMASK
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrAny;
    logic             wrXfer;
    logic             wrMask;
    logic             wrGlob;
    logic [IDX_W-1:0] idx;
    logic             hi;
    regSel_e          rdSel;
    logic             commit;
    logic             fetch;
  } ctrlStb_t;
endpackage

// File: rtl/mxfer_ctrl.sv
module mxfer_ctrl
  import mxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              commitStb,
  input  logic              fetchStb,
  output ctrlStb_t          stb
);

  logic [4:0] rdOff;
  logic [4:0] maskOff;

  // the read and mask windows each span fewer than 32 addresses,
  // so a 5-bit offset wraps correctly
  assign rdOff   = hostAddr[4:0] - RD_BASE[4:0];
  assign maskOff = hostAddr[4:0] - MASK_BASE[4:0];

  always_comb begin
    stb        = '0;
    stb.rdSel  = SEL_NONE;
    stb.wrAny  = hostWrEn;
    stb.commit = commitStb;
    stb.fetch  = fetchStb;
    if (hostAddr < RD_BASE) begin
      stb.rdSel  = SEL_WR;
      stb.idx    = hostAddr[4:1];
      stb.hi     = hostAddr[0];
      stb.wrXfer = hostWrEn;
    end else if (hostAddr < MASK_BASE) begin
      stb.rdSel = SEL_RD;
      stb.idx   = rdOff[4:1];
      stb.hi    = rdOff[0];
    end else if (hostAddr < GMASK_ADDR) begin
      stb.rdSel  = SEL_MASK;
      stb.idx    = maskOff[4:1];
      stb.hi     = maskOff[0];
      stb.wrMask = hostWrEn;
    end else if (hostAddr == GMASK_ADDR) begin
      stb.rdSel  = SEL_GMASK;
      stb.wrGlob = hostWrEn;
    end
  end

  // R4: a host write lands in at most one register group
  assert_single_target_R4 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrXfer, stb.wrMask, stb.wrGlob}));

  // R11: no register write strobe without a host write
  assert_no_spurious_write_R11 : assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |-> !(stb.wrXfer || stb.wrMask || stb.wrGlob));

endmodule

// File: rtl/mxfer_datapath.sv
module mxfer_datapath
  import mxfer_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int ENT_AW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [HALF_W-1:0] hostWrData,
  input  logic [ENT_AW-1:0] entryAddr,
  output logic [HALF_W-1:0] hostRdData
);

  logic [DWORDS-1:0][DW_W-1:0]    wrReg;
  logic [DWORDS-1:0][DW_W-1:0]    rdReg;
  logic [BITMASKED-1:0][DW_W-1:0] maskReg;
  logic [GLOB_W-1:0]              gMask;
  logic [DWORDS-1:0][DW_W-1:0]    mem [ENTRIES];
  logic [DWORDS-1:0][DW_W-1:0]    memWord;
  logic [DWORDS-1:0][DW_W-1:0]    merged;
  logic [DWORDS-1:0]              writeEn;

  assign memWord = mem[entryAddr];

  // host register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReg   <= '0;
      maskReg <= '0;
      gMask   <= '0;
    end else begin
      if (stb.wrXfer) begin
        if (stb.hi) wrReg[stb.idx][DW_W-1:HALF_W] <= hostWrData;
        else        wrReg[stb.idx][HALF_W-1:0]    <= hostWrData;
      end
      if (stb.wrMask) begin
        if (stb.hi) maskReg[stb.idx[MIDX_W-1:0]][DW_W-1:HALF_W] <= hostWrData;
        else        maskReg[stb.idx[MIDX_W-1:0]][HALF_W-1:0]    <= hostWrData;
      end
      if (stb.wrGlob) gMask <= hostWrData[GLOB_W-1:0];
    end
  end

  // merge of staged data into the addressed entry
  for (genvar n = 0; n < DWORDS; n++) begin : g_merge
    if (n < BITMASKED) begin : g_bit
      logic [DW_W-1:0] m;
      logic [DW_W-1:0] blend;
      assign m          = maskReg[n];
      assign blend      = (memWord[n] & ~m) | (wrReg[n] & m);
      assign writeEn[n] = |m;
      assign merged[n]  = {(^blend[DW_W-2:0]) ^ (wrReg[n][DW_W-1] & m[DW_W-1]),
                           blend[DW_W-2:0]};

      // R5: an all-zero mask leaves the stored word intact
      assert_zero_mask_hold_R5 : assert property (@(posedge clk) disable iff (!rstN)
        stb.commit && (maskReg[n] == '0)
        |=> mem[$past(entryAddr)][n] == $past(memWord[n]));

      // R7: without an enabled bit 31 the stored word has even parity
      assert_check_even_R7 : assert property (@(posedge clk) disable iff (!rstN)
        stb.commit && (|maskReg[n]) && !maskReg[n][DW_W-1]
        |=> (^mem[$past(entryAddr)][n]) == 1'b0);
    end else begin : g_glob
      assign writeEn[n] = gMask[n-BITMASKED];
      assign merged[n]  = {(^wrReg[n][DW_W-2:0]) ^ wrReg[n][DW_W-1],
                           wrReg[n][DW_W-2:0]};

      // R6: a disabled word survives the commit
      assert_glob_hold_R6 : assert property (@(posedge clk) disable iff (!rstN)
        stb.commit && !gMask[n-BITMASKED]
        |=> mem[$past(entryAddr)][n] == $past(memWord[n]));
    end

    // R8: fetched data bits match the entry seen at the strobe
    assert_fetch_data_R8 : assert property (@(posedge clk) disable iff (!rstN)
      stb.fetch |=> rdReg[n][DW_W-2:0] == $past(memWord[n][DW_W-2:0]));
  end

  // RAM array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else if (stb.commit) begin
      for (int n = 0; n < DWORDS; n++)
        if (writeEn[n]) mem[entryAddr][n] <= merged[n];
    end
  end

  // read transfer registers: bit 31 becomes the parity check result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (stb.fetch) begin
      for (int n = 0; n < DWORDS; n++)
        rdReg[n] <= {^memWord[n], memWord[n][DW_W-2:0]};
    end
  end

  // host read mux
  always_comb begin
    hostRdData = '0;
    unique case (stb.rdSel)
      SEL_WR:    hostRdData = stb.hi ? wrReg[stb.idx][DW_W-1:HALF_W]
                                     : wrReg[stb.idx][HALF_W-1:0];
      SEL_RD:    hostRdData = stb.hi ? rdReg[stb.idx][DW_W-1:HALF_W]
                                     : rdReg[stb.idx][HALF_W-1:0];
      SEL_MASK:  hostRdData = stb.hi ? maskReg[stb.idx[MIDX_W-1:0]][DW_W-1:HALF_W]
                                     : maskReg[stb.idx[MIDX_W-1:0]][HALF_W-1:0];
      SEL_GMASK: hostRdData = {{(HALF_W-GLOB_W){1'b0}}, gMask};
      default:   hostRdData = '0;
    endcase
  end

  // R3: host writes into the read window leave the read words alone
  assert_rd_readonly_R3 : assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAny && (stb.rdSel == SEL_RD) && !stb.fetch |=> $stable(rdReg));

  // R11: unmapped addresses return zero
  assert_unmapped_zero_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == SEL_NONE) |-> hostRdData == '0);

endmodule

// File: rtl/masked_entry_gateway.sv
module masked_entry_gateway
  import mxfer_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic                       hostWrEn,
  input  logic [HALF_W-1:0]          hostWrData,
  output logic [HALF_W-1:0]          hostRdData,
  input  logic [$clog2(ENTRIES)-1:0] entryAddr,
  input  logic                       commitStb,
  input  logic                       fetchStb
);

  ctrlStb_t stb;

  mxfer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostWrEn  (hostWrEn),
    .commitStb (commitStb),
    .fetchStb  (fetchStb),
    .stb       (stb)
  );

  mxfer_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWrData (hostWrData),
    .entryAddr  (entryAddr),
    .hostRdData (hostRdData)
  );

endmodule

// File: tb/masked_entry_gateway_tb.sv
module masked_entry_gateway_tb;
  localparam int ENTRIES = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic [1:0]  entryAddr = '0;
  logic        commitStb = 1'b0;
  logic        fetchStb = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  masked_entry_gateway #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .entryAddr(entryAddr),
    .commitStb(commitStb), .fetchStb(fetchStb)
  );

  // behavioural reference model
  logic [31:0] mWr [14];
  logic [31:0] mRd [14];
  logic [31:0] mMask [7];
  logic [6:0]  mGm;
  logic [31:0] mRam [ENTRIES][14];

  int  nChecks = 0;
  int  nFails  = 0;
  bit  compareOn = 1'b0;
  bit  done = 1'b0;

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] half(input logic [31:0] w, input int hi);
    return (hi != 0) ? w[31:16] : w[15:0];
  endfunction

  function automatic logic [15:0] modelRead(input int a);
    if (a < 'h1C) return half(mWr[a/2], a % 2);
    if (a < 'h38) return half(mRd[(a-'h1C)/2], (a-'h1C) % 2);
    if (a < 'h46) return half(mMask[(a-'h38)/2], (a-'h38) % 2);
    if (a == 'h46) return {9'b0, mGm};
    return 16'h0;
  endfunction

  function automatic string reqOf(input int a);
    if (a < 'h1C) return "R2";
    if (a < 'h38) return "R3";
    if (a <= 'h46) return "R4";
    return "R11";
  endfunction

  task automatic modelWrite(input int a, input logic [15:0] d);
    if (a < 'h1C) begin
      if (a % 2 != 0) mWr[a/2][31:16] = d; else mWr[a/2][15:0] = d;
    end else if (a >= 'h38 && a < 'h46) begin
      if ((a-'h38) % 2 != 0) mMask[(a-'h38)/2][31:16] = d;
      else mMask[(a-'h38)/2][15:0] = d;
    end else if (a == 'h46) begin
      mGm = d[6:0];
    end
  endtask

  task automatic modelCommit(input int e);
    for (int n = 0; n < 7; n++) begin
      logic [31:0] b;
      if (mMask[n] != 0) begin
        b = (mRam[e][n] & ~mMask[n]) | (mWr[n] & mMask[n]);
        mRam[e][n] = {(^b[30:0]) ^ (mWr[n][31] & mMask[n][31]), b[30:0]};
      end
    end
    for (int n = 7; n < 14; n++)
      if (mGm[n-7]) mRam[e][n] = {(^mWr[n][30:0]) ^ mWr[n][31], mWr[n][30:0]};
  endtask

  task automatic modelFetch(input int e);
    for (int n = 0; n < 14; n++) mRd[n] = {^mRam[e][n], mRam[e][n][30:0]};
  endtask

  // per-clock comparison of the read port against the model
  always @(negedge clk) begin
    if (compareOn && !done)
      check(reqOf(int'(hostAddr)), hostRdData, modelRead(int'(hostAddr)),
            "per-clock read port");
  end

  // stimulus tasks: each starts and ends 1 ns after a rising edge
  task automatic hostWrite(input int a, input logic [15:0] d);
    hostAddr = 7'(a); hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic wrWord(input int n, input logic [31:0] v);
    hostWrite(2*n, v[15:0]);
    hostWrite(2*n+1, v[31:16]);
  endtask

  task automatic maskWord(input int n, input logic [31:0] v);
    hostWrite('h38 + 2*n, v[15:0]);
    hostWrite('h39 + 2*n, v[31:16]);
  endtask

  task automatic commitEntry(input int e);
    entryAddr = 2'(e); commitStb = 1'b1;
    @(posedge clk); #1;
    commitStb = 1'b0;
    modelCommit(e);
  endtask

  task automatic fetchEntry(input int e);
    entryAddr = 2'(e); fetchStb = 1'b1;
    @(posedge clk); #1;
    fetchStb = 1'b0;
    modelFetch(e);
  endtask

  task automatic commitAndFetch(input int e);
    entryAddr = 2'(e); commitStb = 1'b1; fetchStb = 1'b1;
    @(posedge clk); #1;
    commitStb = 1'b0; fetchStb = 1'b0;
    modelFetch(e);
    modelCommit(e);
  endtask

  task automatic commitWithWrite(input int e, input int a, input logic [15:0] d);
    entryAddr = 2'(e); commitStb = 1'b1;
    hostAddr = 7'(a); hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    commitStb = 1'b0; hostWrEn = 1'b0;
    modelCommit(e);
    modelWrite(a, d);
  endtask

  task automatic readAt(input int a, input string req);
    hostAddr = 7'(a);
    @(negedge clk);
    check(req, hostRdData, modelRead(a), "register read");
    @(posedge clk); #1;
  endtask

  task automatic readZero(input int a, input string req);
    hostAddr = 7'(a);
    @(negedge clk);
    check(req, hostRdData, 16'h0, "expected zero");
    @(posedge clk); #1;
  endtask

  task automatic probeCheckBit(input int n, input logic expBit, input string req);
    hostAddr = 7'('h1D + 2*n);
    @(negedge clk);
    check(req, {15'b0, hostRdData[15]}, {15'b0, expBit}, "parity flag");
    @(posedge clk); #1;
  endtask

  task automatic readAllRd(input string req);
    for (int a = 'h1C; a < 'h38; a++) readAt(a, req);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 14; n++) begin mWr[n] = '0; mRd[n] = '0; end
    for (int n = 0; n < 7; n++) mMask[n] = '0;
    mGm = '0;
    for (int e = 0; e < ENTRIES; e++)
      for (int n = 0; n < 14; n++) mRam[e][n] = '0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: every mapped and some unmapped registers read zero
    for (int a = 0; a <= 'h47; a++) readZero(a, "R1");
    fetchEntry(2);
    readZero('h1C, "R1");
    readZero('h37, "R1");
    compareOn = 1'b1;

    // R2: staged word halves, bit 31 clear
    for (int n = 0; n < 14; n++) wrWord(n, (32'h13579BDF * (n+1)) & 32'h7FFF_FFFF);
    for (int a = 0; a < 'h1C; a++) readAt(a, "R2");

    // R3: writes into read window ignored
    for (int a = 'h1C; a < 'h38; a++) hostWrite(a, 16'hFFFF);
    readZero('h1C, "R3");
    readZero('h2B, "R3");
    readZero('h37, "R3");

    // R4: masks and global mask
    for (int n = 0; n < 7; n++) maskWord(n, 32'hFFFF_FFFF);
    hostWrite('h46, 16'hFFFF);
    for (int a = 'h38; a <= 'h46; a++) readAt(a, "R4");
    hostAddr = 7'h46;
    @(negedge clk);
    check("R4", hostRdData, 16'h007F, "global mask upper bits zero");
    @(posedge clk); #1;

    // R5 R6 R8: full write into entry 1, fetch it back
    commitEntry(1);
    fetchEntry(1);
    readAllRd("R8");
    for (int n = 0; n < 14; n++) probeCheckBit(n, 1'b0, "R7");

    // R10: other entries untouched
    fetchEntry(0);
    readZero('h1C, "R10");
    readZero('h36, "R10");
    fetchEntry(3);
    readAllRd("R10");

    // R5 R6: partial masks over existing entry 1
    for (int n = 0; n < 14; n++) wrWord(n, 32'h2468ACE0 ^ (32'h0F0F1111 * n));
    maskWord(0, 32'h0F0F_0F0F);
    maskWord(1, 32'h00FF_00FF);
    maskWord(2, 32'h7000_0001);
    maskWord(3, 32'h0000_0000);
    maskWord(4, 32'h5555_AAAA);
    maskWord(5, 32'h0001_8000);
    maskWord(6, 32'h7FFF_FFFF);
    hostWrite('h46, 16'h002A);
    commitEntry(1);
    fetchEntry(1);
    readAllRd("R5");
    readAt('h1C + 6, "R5");
    readAt('h1C + 16, "R6");
    readAt('h1C + 18, "R6");

    // R7: parity error injection on word 2 and word 9 of entry 3
    for (int n = 0; n < 7; n++) maskWord(n, 32'h0);
    wrWord(2, 32'h8000_1234);
    maskWord(2, 32'h8000_FFFF);
    wrWord(9, 32'h8765_4321);
    hostWrite('h46, 16'h0004);
    commitEntry(3);
    fetchEntry(3);
    probeCheckBit(2, 1'b1, "R7");
    probeCheckBit(9, 1'b1, "R7");
    probeCheckBit(0, 1'b0, "R7");
    readAllRd("R8");

    // R7: clean rewrite repairs the check bit
    wrWord(2, 32'h0000_0001);
    maskWord(2, 32'h0000_0001);
    hostWrite('h46, 16'h0000);
    commitEntry(3);
    fetchEntry(3);
    probeCheckBit(2, 1'b0, "R7");
    probeCheckBit(9, 1'b1, "R7");

    // R9: commit and fetch together return old contents
    wrWord(8, 32'h1122_3344);
    hostWrite('h46, 16'h0002);
    commitAndFetch(3);
    readZero('h1C + 16, "R9");
    fetchEntry(3);
    readAt('h1C + 16, "R9");
    readAt('h1D + 16, "R9");

    // R9: host write in the commit cycle is not used by that commit
    commitWithWrite(0, 16, 16'hBEEF);
    fetchEntry(0);
    readAt('h1C + 16, "R9");
    commitEntry(0);
    fetchEntry(0);
    readAt('h1C + 16, "R9");

    // R11: unmapped writes ignored, reads zero
    for (int a = 'h47; a < 'h80; a += 5) hostWrite(a, 16'hFFFF);
    hostWrite('h7F, 16'hFFFF);
    readZero('h47, "R11");
    readZero('h7F, "R11");
    readAt('h46, "R11");
    readAt('h00, "R11");

    // R12: read data follows the address within the same cycle
    hostAddr = 7'h46;
    #2;
    check("R12", hostRdData, modelRead('h46), "same-cycle read");
    hostAddr = 7'h01;
    #1;
    check("R12", hostRdData, modelRead('h01), "same-cycle read");
    @(posedge clk); #1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule